// File: doc/BRIEF.md
# Lockable Memory-Window Base Register

This block holds one 64-bit configuration register that places a naturally aligned 32 KB register window somewhere in the low 512 GB of memory space. It also contains the matching address decoder. Software programs the register through a small configuration port. The port presents a dword-aligned offset, a 64-bit write payload with eight byte enables, and a 32-bit read path.

A separate memory-address input is decoded combinationally. The decoder raises a claim flag when the address falls inside the programmed window and the window enable bit is set. It also presents the 15-bit offset of that address within the window.

A lock input models a trusted-execution mode. While the lock is high, configuration writes cannot move the window or switch it on or off.

Top module: `winbase_reg`

## Requirements
- R1: After reset, reads at offsets 0x048 and 0x04C both return zero and `mem_hit` is low for every address.
- R2: Register bits 38:15 hold the window base and can be written and read back. The low dword (offset 0x048) returns base bits 16:0 in data bits 31:15. The high dword (offset 0x04C) returns base bits 23:17 in data bits 6:0.
- R3: Register bits 63:39 and 14:1 always read as zero, and writes to them are ignored. In the low dword, data bits 14:1 are zero. In the high dword, data bits 31:7 are zero.
- R4: A write at offset 0x048 updates only the bytes whose `cfg_be` bit is set. `cfg_be[k]` covers register bits 8k+7:8k.
- R5: Register bit 0 is the window enable. While it is 0, `mem_hit` stays low whatever the address.
- R6: With the enable set, `mem_hit` is high exactly when `mem_addr[63:39]` is zero and `mem_addr[38:15]` equals the base. `mem_ofs` always equals `mem_addr[14:0]`. Both outputs follow `mem_addr` in the same cycle.
- R7: A write taken on a clock edge where `lock_i` is high changes neither the base nor the enable. This includes the first cycle in which the lock rises.
- R8: Writes at any offset other than 0x048 leave the register unchanged. Reads at any offset other than 0x048 and 0x04C return zero.
- R9: A write accepted on a clock edge changes the decode from that edge onward. Before that edge, the decode still reflects the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_off | input | 12 | Dword-aligned configuration offset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_be | input | 8 | Byte enables for the 64-bit register |
| cfg_wdata | input | 64 | Write payload |
| cfg_rdata | output | 32 | Read data for the dword selected by `cfg_off` |
| lock_i | input | 1 | Trusted-mode lock; freezes writable fields |
| mem_addr | input | 64 | Memory address to decode |
| mem_hit | output | 1 | Address claimed by the window |
| mem_ofs | output | 15 | Offset of `mem_addr` inside the window |

## Verification
The assertions check several rules on every cycle:
- A claim never occurs with the enable clear.
- A claimed address always has zero upper bits and a window field equal to the stored base.
- Reserved read bits stay zero.
- The stored fields do not move after a locked write or a write to a foreign offset.

Other behaviour only the bench scenarios can show:
- Byte-enable merging against a model.
- Exact readback bit placement.
- The window edges at offsets 0 and 0x7FFF and just outside them.
- The one-cycle delay between a write and the new decode.

// File: rtl/winbase_pkg.sv
package winbase_pkg;
    localparam int REG_W      = 64;
    localparam int BASE_LO    = 15;
    localparam int BASE_HI    = 38;
    localparam int BASE_W     = BASE_HI - BASE_LO + 1;
    localparam int TOP_PAD    = REG_W - 1 - BASE_HI;
    localparam int MID_PAD    = BASE_LO - 1;
    localparam int NBYTES     = REG_W / 8;
    localparam int CFG_OFF_W  = 12;
    localparam logic [CFG_OFF_W-1:0] REG_OFF_LO = 12'h048;
    localparam logic [CFG_OFF_W-1:0] REG_OFF_HI = 12'h04C;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              en;
    } win_state_t;

    function automatic logic [REG_W-1:0] pack_reg(input win_state_t s);
        return {{TOP_PAD{1'b0}}, s.base, {MID_PAD{1'b0}}, s.en};
    endfunction
endpackage

// File: rtl/winbase_field.sv
module winbase_field
    import winbase_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CFG_OFF_W-1:0] cfg_off,
    input  logic                 cfg_we,
    input  logic [NBYTES-1:0]    cfg_be,
    input  logic [REG_W-1:0]     cfg_wdata,
    input  logic                 lock_i,
    output win_state_t           state_o
);
    win_state_t       st_d, st_q;
    logic [REG_W-1:0] merged;
    logic             accept;

    always_comb begin
        accept = cfg_we && !lock_i && (cfg_off == REG_OFF_LO);
        merged = pack_reg(st_q);
        for (int b = 0; b < NBYTES; b++) begin
            if (cfg_be[b]) merged[8*b +: 8] = cfg_wdata[8*b +: 8];
        end
        st_d = st_q;
        if (accept) begin
            st_d.base = merged[BASE_HI:BASE_LO];
            st_d.en   = merged[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/winbase_rdmux.sv
module winbase_rdmux
    import winbase_pkg::*;
(
    input  logic [CFG_OFF_W-1:0] cfg_off,
    input  win_state_t           state_i,
    output logic [31:0]          rdata_o
);
    logic [REG_W-1:0] full;

    always_comb begin
        full = pack_reg(state_i);
        if (cfg_off == REG_OFF_LO)      rdata_o = full[31:0];
        else if (cfg_off == REG_OFF_HI) rdata_o = full[63:32];
        else                            rdata_o = '0;
    end
endmodule

// File: rtl/winbase_decode.sv
module winbase_decode
    import winbase_pkg::*;
(
    input  logic [REG_W-1:0] addr_i,
    input  win_state_t       state_i,
    output logic             hit_o,
    output logic [BASE_LO-1:0] ofs_o
);
    logic upper_clear;
    logic base_match;

    always_comb begin
        upper_clear = (addr_i[REG_W-1:BASE_HI+1] == '0);
        base_match  = (addr_i[BASE_HI:BASE_LO] == state_i.base);
        hit_o       = state_i.en && upper_clear && base_match;
        ofs_o       = addr_i[BASE_LO-1:0];
    end
endmodule

// File: rtl/winbase_reg.sv
module winbase_reg
    import winbase_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CFG_OFF_W-1:0] cfg_off,
    input  logic                 cfg_we,
    input  logic [NBYTES-1:0]    cfg_be,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic                 lock_i,
    input  logic [REG_W-1:0]     mem_addr,
    output logic                 mem_hit,
    output logic [BASE_LO-1:0]   mem_ofs
);
    win_state_t        state;
    logic [BASE_W-1:0] base_q;
    logic              en_q;

    winbase_field u_field (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_off   (cfg_off),
        .cfg_we    (cfg_we),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .lock_i    (lock_i),
        .state_o   (state)
    );

    winbase_rdmux u_rdmux (
        .cfg_off (cfg_off),
        .state_i (state),
        .rdata_o (cfg_rdata)
    );

    winbase_decode u_decode (
        .addr_i  (mem_addr),
        .state_i (state),
        .hit_o   (mem_hit),
        .ofs_o   (mem_ofs)
    );

    assign base_q = state.base;
    assign en_q   = state.en;
endmodule

// File: rtl/winbase_chk.sv
module winbase_chk
    import winbase_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [CFG_OFF_W-1:0] cfg_off,
    input logic                 cfg_we,
    input logic [31:0]          cfg_rdata,
    input logic                 lock_i,
    input logic [REG_W-1:0]     mem_addr,
    input logic                 mem_hit,
    input logic [BASE_W-1:0]    base_q,
    input logic                 en_q
);
    AST_NO_HIT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !mem_hit); // R5
    AST_HIT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> (mem_addr[REG_W-1:BASE_HI+1] == '0)); // R6
    AST_HIT_BASE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> (mem_addr[BASE_HI:BASE_LO] == base_q)); // R6
    AST_RSVD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_off == REG_OFF_LO) |-> (cfg_rdata[MID_PAD:1] == '0)); // R3
    AST_RSVD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_off == REG_OFF_HI) |-> (cfg_rdata[31:BASE_HI-31] == '0)); // R3
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> ($stable(base_q) && $stable(en_q))); // R7
    AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_off != REG_OFF_LO) |=> ($stable(base_q) && $stable(en_q))); // R8
endmodule

bind winbase_reg winbase_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_off   (cfg_off),
    .cfg_we    (cfg_we),
    .cfg_rdata (cfg_rdata),
    .lock_i    (lock_i),
    .mem_addr  (mem_addr),
    .mem_hit   (mem_hit),
    .base_q    (base_q),
    .en_q      (en_q)
);

// File: tb/winbase_reg_bench.sv
module winbase_reg_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [11:0] cfg_off = 0;
    logic        cfg_we = 0;
    logic [7:0]  cfg_be = 0;
    logic [63:0] cfg_wdata = 0;
    logic [31:0] cfg_rdata;
    logic        lock_i = 0;
    logic [63:0] mem_addr = 0;
    logic        mem_hit;
    logic [14:0] mem_ofs;

    int checks = 0;
    int errors = 0;
    logic [23:0] m_base = 0;
    logic        m_en = 0;

    always #5 clk = ~clk;

    winbase_reg u_winbase_reg (
        .clk(clk), .rst_n(rst_n), .cfg_off(cfg_off), .cfg_we(cfg_we),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lock_i(lock_i), .mem_addr(mem_addr), .mem_hit(mem_hit), .mem_ofs(mem_ofs)
    );

    function automatic logic [31:0] exp_lo(input logic [23:0] b, input logic e);
        return {b[16:0], 14'b0, e};
    endfunction
    function automatic logic [31:0] exp_hi(input logic [23:0] b);
        return {25'b0, b[23:17]};
    endfunction
    function automatic logic exp_hit(input logic [63:0] a, input logic [23:0] b, input logic e);
        return e && (a[63:39] == 25'b0) && (a[38:15] == b);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [11:0] off, input logic [7:0] be,
                               input logic [63:0] d, input logic lk);
        logic [63:0] cur;
        cur = {25'b0, m_base, 14'b0, m_en};
        if (!lk && off == 12'h048) begin
            for (int b = 0; b < 8; b++) if (be[b]) cur[8*b +: 8] = d[8*b +: 8];
            m_base = cur[38:15];
            m_en   = cur[0];
        end
    endtask

    task automatic do_write(input logic [11:0] off, input logic [7:0] be,
                            input logic [63:0] d, input logic lk);
        @(negedge clk);
        cfg_off = off; cfg_be = be; cfg_wdata = d; cfg_we = 1; lock_i = lk;
        @(negedge clk);
        cfg_we = 0; lock_i = 0;
        model_write(off, be, d, lk);
    endtask

    task automatic check_regs(input string req);
        @(negedge clk);
        cfg_off = 12'h048; #1;
        check(req, {32'b0, cfg_rdata}, {32'b0, exp_lo(m_base, m_en)});
        cfg_off = 12'h04C; #1;
        check(req, {32'b0, cfg_rdata}, {32'b0, exp_hi(m_base)});
    endtask

    task automatic check_addr(input string req, input logic [63:0] a);
        mem_addr = a; #1;
        check(req, {63'b0, mem_hit}, {63'b0, exp_hit(a, m_base, m_en)});
        check("R6", {49'b0, mem_ofs}, {49'b0, a[14:0]});
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] wb;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check_regs("R1");
        check_addr("R1", 64'h0);
        check_addr("R1", 64'h7FFF);

        // R5: base set but enable clear gives no hit
        do_write(12'h048, 8'hFF, {25'h1FFFFFF, 24'hABCDE1, 14'h3FFF, 1'b0}, 0);
        check_regs("R3");
        check_addr("R5", {25'b0, 24'hABCDE1, 15'h0123});

        // R4: only byte 0 written sets enable, base untouched
        do_write(12'h048, 8'h01, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        check_regs("R4");
        check("R4", {63'b0, m_en}, 64'd1);

        // R6: window edges
        wb = {25'b0, m_base, 15'b0};
        check_addr("R6", wb);
        check_addr("R6", wb + 64'h7FFF);
        check_addr("R6", wb - 64'h1);
        check_addr("R6", wb + 64'h8000);
        check_addr("R6", wb | 64'h0000_0080_0000_0000);

        // R7: write during lock rejected
        do_write(12'h048, 8'hFF, 64'h0, 1);
        check_regs("R7");
        check_addr("R7", wb + 64'h10);

        // R8: foreign offset write ignored, foreign read zero
        do_write(12'h04C, 8'hFF, 64'h0, 0);
        check_regs("R8");
        @(negedge clk); cfg_off = 12'h050; #1;
        check("R8", {32'b0, cfg_rdata}, 64'h0);

        // R9: new decode only after the write edge
        @(negedge clk);
        cfg_off = 12'h048; cfg_be = 8'hFF; cfg_we = 1; lock_i = 0;
        cfg_wdata = {25'b0, 24'h000123, 14'b0, 1'b1};
        mem_addr = {25'b0, 24'h000123, 15'h0042}; #1;
        check("R9", {63'b0, mem_hit}, 64'd0);
        @(negedge clk);
        cfg_we = 0;
        model_write(12'h048, 8'hFF, {25'b0, 24'h000123, 14'b0, 1'b1}, 0);
        #1;
        check("R9", {63'b0, mem_hit}, 64'd1);

        // R2: directed readback of full base
        do_write(12'h048, 8'hFF, {25'b0, 24'hFFFFFF, 14'b0, 1'b1}, 0);
        check_regs("R2");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [11:0] off;
            logic [63:0] a;
            off = ($urandom % 4 == 0) ? 12'h04C : 12'h048;
            do_write(off, 8'($urandom), {$urandom, $urandom}, ($urandom % 4) == 0);
            check_regs("R2");
            a = {$urandom, $urandom};
            if ($urandom % 2) a = {25'b0, m_base, a[14:0]};
            check_addr("R6", a);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule